// File: doc/BRIEF.md
# Framed 24-Bit Serial Register Slave

This block is the slave side of a serial write port in front of a four-channel converter register file. It oversamples the serial clock, the active-low frame select, the data input and the active-low load strobe in a fast system clock. While the frame select is low it shifts the data line in on every falling serial-clock edge. When the frame select rises it commits the collected 24-bit word to the addressed register, or discards it if the edge count was wrong. Each channel has a 16-bit input register and a 16-bit output register. A falling edge on the load strobe, taken while no frame is open, moves all input registers to the outputs together.

The shift register's top bit drives the serial output, so words clocked in beyond the 24th edge leave the block for the next slave in a chain. A chain-mode input relaxes the commit rule so that each slave keeps the last 24 bits it received. A frame with the read flag set arms a readback. The next frame shifts the selected register out on the serial output, even if the output has been switched off through the control register.

Top module: `dac_ser_slave`

## Requirements
- R1: Word layout: bit 23 read flag, bits 21:19 register select, bits 18:16 channel (0 to 3), bits 15:0 data. The first bit shifted in is bit 23. A frame of exactly 24 falling edges with read flag 0 and select 000 writes the data to the input register of that channel. Channels 4 to 7 are ignored.
- R2: A frame that ends after fewer than 24 falling edges, including zero, changes no register.
- R3: With chain mode off, a frame of more than 24 falling edges changes no register.
- R4: With chain mode on, a frame of 24 or more falling edges commits the last 24 bits shifted in.
- R5: The serial output shows the shift register's top bit and changes only on rising serial-clock edges and at frame start. In a 48-edge frame, the output sampled before falling edges 25 to 48 is the first 24 bits shifted in, in order.
- R6: Serial-clock edges while the frame select is high load nothing and leave the serial output unchanged.
- R7: A falling load strobe while the frame select is high copies all four input registers to the output registers at once. A falling load strobe during a frame has no effect.
- R8: A committed frame with read flag 1 selects a register. During the next frame the serial output shifts out, MSB first, the word {0, request bits 22:16, register value}. Select 000 reads a channel's input register, and select 011 with channel 001 reads the control register.
- R9: A write with select 011 and channel 001 stores data bit 0 as output-disable. While it is set, the output enable is low and the serial output is held at 0, except during the frame that follows a read request. Select 011 with channel 000 is a no-operation.
- R10: After reset all registers read 0, the output enable is 1 and the serial output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock, idles high |
| sync_n_i | input | 1 | Active-low frame select |
| sdin_i | input | 1 | Serial data in |
| ldac_n_i | input | 1 | Active-low load strobe |
| chain_en_i | input | 1 | 1: commit last 24 bits of a longer frame |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Serial output enable |
| dac_code_o | output | 64 | Output registers, channel n at bits 16n+15:16n |

## Verification
The properties assume that every input level lasts several system clocks, that serial-clock edges are at least four system clocks apart, and that the frame select never moves in the same sampled cycle as a serial-clock edge. The stimulus holds each serial-clock phase for four system clocks. It changes the data line only with a rising serial-clock edge, waits six clocks after each frame-select transition, and keeps chain mode constant within a frame.

// File: rtl/dac_ser_pkg.sv
package dac_ser_pkg;
  localparam int FRAME_BITS = 24;
  localparam int DATA_W     = 16;
  localparam int RD_BIT     = 23;
  localparam int SEL_HI     = 21;
  localparam int SEL_LO     = 19;
  localparam int CH_HI      = 18;
  localparam int CH_LO      = 16;
  localparam logic [2:0] SEL_CHAN = 3'b000;
  localparam logic [2:0] SEL_CTRL = 3'b011;
  localparam logic [2:0] CTRL_SDO = 3'b001;
endpackage

// File: rtl/dac_sig_sync.sv
module dac_sig_sync #(
  parameter int N = 4,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] meta_q, lvl_q, prev_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[g] <= RST_VAL[g];
        lvl_q[g]  <= RST_VAL[g];
        prev_q[g] <= RST_VAL[g];
      end else begin
        meta_q[g] <= d_i[g];
        lvl_q[g]  <= meta_q[g];
        prev_q[g] <= lvl_q[g];
      end
    end
    assign rise_o[g] = lvl_q[g] & ~prev_q[g];
    assign fall_o[g] = ~lvl_q[g] & prev_q[g];
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/dac_frame_shifter.sv
module dac_frame_shifter #(
  parameter int FB = 24,
  parameter int CW = $clog2(FB + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sync_lvl_i,
  input  logic          sync_fall_i,
  input  logic          sync_rise_i,
  input  logic          sclk_fall_i,
  input  logic          sclk_rise_i,
  input  logic          sdin_i,
  input  logic          chain_i,
  input  logic          preload_vld_i,
  input  logic [FB-1:0] preload_i,
  output logic [FB-1:0] word_o,
  output logic [CW-1:0] cnt_o,
  output logic          commit_o,
  output logic          sdo_o
);
  localparam logic [CW-1:0] CNT_FULL = CW'(FB);
  localparam logic [CW-1:0] CNT_MAX  = CW'(FB + 1);

  logic [FB-1:0] sh_q, sh_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          sdo_q, sdo_d;
  logic          upd;

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    sdo_d = sdo_q;
    if (sync_fall_i) begin
      cnt_d = '0;
      sh_d  = preload_vld_i ? preload_i : '0;
      sdo_d = sh_d[FB-1];
    end else if (!sync_lvl_i) begin
      if (sclk_fall_i) begin
        sh_d = {sh_q[FB-2:0], sdin_i};
        if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
      end
      if (sclk_rise_i) sdo_d = sh_q[FB-1];
    end
  end

  assign upd = sync_fall_i | (~sync_lvl_i & (sclk_fall_i | sclk_rise_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
      sdo_q <= 1'b0;
    end else if (upd) begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      sdo_q <= sdo_d;
    end
  end

  assign commit_o = sync_rise_i & (chain_i ? (cnt_q >= CNT_FULL) : (cnt_q == CNT_FULL));
  assign word_o   = sh_q;
  assign cnt_o    = cnt_q;
  assign sdo_o    = sdo_q;
endmodule

// File: rtl/dac_reg_bank.sv
module dac_reg_bank
  import dac_ser_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 16,
  parameter int FB  = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_i,
  input  logic [FB-1:0]     word_i,
  input  logic              sync_lvl_i,
  input  logic              sync_fall_i,
  input  logic              sync_rise_i,
  input  logic              ldac_fall_i,
  output logic [NCH*DW-1:0] in_flat_o,
  output logic [NCH*DW-1:0] dac_flat_o,
  output logic              rb_vld_o,
  output logic [FB-1:0]     rb_word_o,
  output logic              rb_active_o,
  output logic              sdo_dis_o
);
  logic [DW-1:0] in_q [NCH];
  logic [DW-1:0] in_d [NCH];
  logic [DW-1:0] dac_q [NCH];
  logic [DW-1:0] dac_d [NCH];
  logic          dis_q, dis_d, pend_q, pend_d, act_q, act_d;
  logic [FB-1:0] rbw_q, rbw_d;
  logic [2:0]    sel, chn;
  logic          rd_req, chn_ok;
  logic [DW-1:0] rd_val;

  assign sel    = word_i[SEL_HI:SEL_LO];
  assign chn    = word_i[CH_HI:CH_LO];
  assign rd_req = word_i[RD_BIT];
  assign chn_ok = int'(chn) < NCH;

  always_comb begin
    rd_val = '0;
    if (sel == SEL_CHAN) begin
      for (int c = 0; c < NCH; c++)
        if (int'(chn) == c) rd_val = in_q[c];
    end else if (sel == SEL_CTRL && chn == CTRL_SDO) begin
      rd_val = DW'(dis_q);
    end
  end

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      in_d[c]  = in_q[c];
      dac_d[c] = ldac_fall_i && sync_lvl_i ? in_q[c] : dac_q[c];
    end
    dis_d  = dis_q;
    pend_d = pend_q;
    act_d  = act_q;
    rbw_d  = rbw_q;
    if (sync_fall_i) begin
      act_d  = pend_q;
      pend_d = 1'b0;
    end
    if (sync_rise_i) act_d = 1'b0;
    if (commit_i) begin
      if (rd_req) begin
        pend_d = 1'b1;
        rbw_d  = {1'b0, word_i[FB-2:DW], rd_val};
      end else if (sel == SEL_CHAN && chn_ok) begin
        for (int c = 0; c < NCH; c++)
          if (int'(chn) == c) in_d[c] = word_i[DW-1:0];
      end else if (sel == SEL_CTRL && chn == CTRL_SDO) begin
        dis_d = word_i[0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        in_q[c]  <= '0;
        dac_q[c] <= '0;
      end
      dis_q  <= 1'b0;
      pend_q <= 1'b0;
      act_q  <= 1'b0;
      rbw_q  <= '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        in_q[c]  <= in_d[c];
        dac_q[c] <= dac_d[c];
      end
      dis_q  <= dis_d;
      pend_q <= pend_d;
      act_q  <= act_d;
      rbw_q  <= rbw_d;
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_flat
    assign in_flat_o[g*DW +: DW]  = in_q[g];
    assign dac_flat_o[g*DW +: DW] = dac_q[g];
  end

  assign rb_vld_o    = pend_q;
  assign rb_word_o   = rbw_q;
  assign rb_active_o = act_q;
  assign sdo_dis_o   = dis_q;
endmodule

// File: rtl/dac_ser_slave.sv
module dac_ser_slave
  import dac_ser_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = DATA_W,
  parameter int FB  = FRAME_BITS,
  parameter int CW  = $clog2(FB + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              sync_n_i,
  input  logic              sdin_i,
  input  logic              ldac_n_i,
  input  logic              chain_en_i,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [NCH*DW-1:0] dac_code_o
);
  logic          rst_meta, rst_n_int;
  logic [3:0]    lvl, rise, fall;
  logic          sync_lvl, sync_fall, sync_rise, sclk_rise, sclk_fall, ldac_fall;
  logic          commit, rb_vld, rb_active, sdo_dis, sdo_q;
  logic [FB-1:0] word, rb_word;
  logic [CW-1:0] cnt;
  logic [NCH*DW-1:0] in_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta  <= 1'b0;
      rst_n_int <= 1'b0;
    end else begin
      rst_meta  <= 1'b1;
      rst_n_int <= rst_meta;
    end
  end

  dac_sig_sync #(.N(4), .RST_VAL(4'b1011)) i_sync (
    .clk(clk), .rst_n(rst_n_int),
    .d_i({ldac_n_i, sdin_i, sync_n_i, sclk_i}),
    .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
  );

  assign sclk_rise = rise[0];
  assign sclk_fall = fall[0];
  assign sync_lvl  = lvl[1];
  assign sync_rise = rise[1];
  assign sync_fall = fall[1];
  assign ldac_fall = fall[3];

  dac_frame_shifter #(.FB(FB), .CW(CW)) i_shift (
    .clk(clk), .rst_n(rst_n_int),
    .sync_lvl_i(sync_lvl), .sync_fall_i(sync_fall), .sync_rise_i(sync_rise),
    .sclk_fall_i(sclk_fall), .sclk_rise_i(sclk_rise), .sdin_i(lvl[2]),
    .chain_i(chain_en_i), .preload_vld_i(rb_vld), .preload_i(rb_word),
    .word_o(word), .cnt_o(cnt), .commit_o(commit), .sdo_o(sdo_q)
  );

  dac_reg_bank #(.NCH(NCH), .DW(DW), .FB(FB)) i_bank (
    .clk(clk), .rst_n(rst_n_int),
    .commit_i(commit), .word_i(word),
    .sync_lvl_i(sync_lvl), .sync_fall_i(sync_fall), .sync_rise_i(sync_rise),
    .ldac_fall_i(ldac_fall),
    .in_flat_o(in_flat), .dac_flat_o(dac_code_o),
    .rb_vld_o(rb_vld), .rb_word_o(rb_word), .rb_active_o(rb_active),
    .sdo_dis_o(sdo_dis)
  );

  assign sdo_oe_o = ~sdo_dis | rb_active;
  assign sdo_o    = sdo_q & sdo_oe_o;
endmodule

// File: rtl/dac_ser_slave_chk.sv
module dac_ser_slave_chk #(
  parameter int NCH = 4,
  parameter int DW  = 16,
  parameter int FB  = 24,
  parameter int CW  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sync_lvl,
  input logic              sync_fall,
  input logic              sync_rise,
  input logic              sclk_rise,
  input logic              ldac_fall,
  input logic              chain_en,
  input logic [CW-1:0]     cnt,
  input logic [FB-1:0]     word,
  input logic              sdo_q,
  input logic [NCH*DW-1:0] in_flat,
  input logic [NCH*DW-1:0] dac_flat
);
  localparam logic [CW-1:0] FULL = CW'(FB);

  p_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sync_fall |=> (cnt == '0));

  p_short_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_rise && cnt < FULL) |=> $stable(in_flat));

  p_overrun_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_rise && !chain_en && cnt > FULL) |=> $stable(in_flat));

  p_sdo_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(sclk_rise || sync_fall) |=> $stable(sdo_q));

  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_lvl |=> $stable(word));

  p_ldac_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(ldac_fall && sync_lvl) |=> $stable(dac_flat));
endmodule

bind dac_ser_slave dac_ser_slave_chk #(.NCH(NCH), .DW(DW), .FB(FB), .CW(CW)) i_chk (
  .clk(clk), .rst_n(rst_n_int), .sync_lvl(sync_lvl), .sync_fall(sync_fall),
  .sync_rise(sync_rise), .sclk_rise(sclk_rise), .ldac_fall(ldac_fall),
  .chain_en(chain_en_i), .cnt(cnt), .word(word), .sdo_q(sdo_q),
  .in_flat(in_flat), .dac_flat(dac_code_o)
);

// File: tb/test_dac_ser_slave.sv
module test_dac_ser_slave;
  logic        clk, rst_n, sclk, sync_n, sdin, ldac_n, chain_en;
  logic        sdo, sdo_oe;
  logic [63:0] dac;

  dac_ser_slave i_dac_ser_slave (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sync_n_i(sync_n), .sdin_i(sdin),
    .ldac_n_i(ldac_n), .chain_en_i(chain_en), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
    .dac_code_o(dac)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    int          sel;
    logic [23:0] exp;
    string       req;
  } item_t;

  item_t       sb_q[$];
  event        chk_ev;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;
  logic [23:0] sdo_cap;
  logic        oe_all;

  // Monitor: sel 0..3 output register of a channel, 4 captured SDO word,
  // 5 output enable, 6 serial output, 7 enable held through last frame
  initial forever begin
    @(chk_ev);
    while (sb_q.size() > 0) begin
      item_t it;
      logic [23:0] act;
      it = sb_q.pop_front();
      case (it.sel)
        0, 1, 2, 3: act = {8'h00, dac[it.sel*16 +: 16]};
        4:          act = sdo_cap;
        5:          act = {23'd0, sdo_oe};
        6:          act = {23'd0, sdo};
        default:    act = {23'd0, oe_all};
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: sel %0d actual %h expected %h", it.req, it.sel, act, it.exp);
      end
    end
  end

  task automatic expect_val(input int sel, input logic [23:0] exp, input string req);
    item_t it;
    it.sel = sel; it.exp = exp; it.req = req;
    sb_q.push_back(it);
    -> chk_ev;
    #1;
  endtask

  task automatic frame(input logic [47:0] bits, input int n);
    oe_all = 1'b1;
    sync_n = 1'b0;
    repeat (6) @(negedge clk);
    for (int i = 0; i < n; i++) begin
      sclk = 1'b1;
      sdin = bits[n-1-i];
      repeat (4) @(negedge clk);
      sdo_cap = {sdo_cap[22:0], sdo};
      oe_all  = oe_all & sdo_oe;
      sclk = 1'b0;
      repeat (4) @(negedge clk);
    end
    sclk = 1'b1;
    repeat (4) @(negedge clk);
    sync_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse_ldac();
    ldac_n = 1'b0;
    repeat (4) @(negedge clk);
    ldac_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; sclk = 1'b1; sync_n = 1'b1; sdin = 1'b0; ldac_n = 1'b1;
    chain_en = 1'b0; sdo_cap = '0; oe_all = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    for (int c = 0; c < 4; c++) expect_val(c, 24'h0, "R10 reset output register");
    expect_val(5, 24'h1, "R10 reset enable");
    expect_val(6, 24'h0, "R10 reset serial output");

    frame(48'h001234, 24);
    frame(48'h02BEEF, 24);
    frame(48'h061111, 24); // channel 6 ignored (R1)
    pulse_ldac();
    expect_val(0, 24'h1234, "R1 write channel 0");
    expect_val(2, 24'hBEEF, "R1 write channel 2");

    frame(48'h015555, 24);
    sync_n = 1'b0;
    repeat (6) @(negedge clk);
    pulse_ldac();
    sync_n = 1'b1;
    repeat (6) @(negedge clk);
    expect_val(1, 24'h0, "R7 load during frame ignored");
    pulse_ldac();
    expect_val(1, 24'h5555, "R7 load copies input; R2 empty frame dropped");

    frame(48'h00AAAA, 20);
    pulse_ldac();
    expect_val(0, 24'h1234, "R2 short frame discarded");

    frame({23'd0, 1'b0, 24'h031111}, 25);
    pulse_ldac();
    expect_val(3, 24'h0, "R3 long frame rejected");

    chain_en = 1'b1;
    repeat (4) @(negedge clk);
    frame({24'h000777, 24'h03CAFE}, 48);
    chain_en = 1'b0;
    expect_val(4, 24'h000777, "R5 overflow bits on serial output");
    pulse_ldac();
    expect_val(3, 24'hCAFE, "R4 chain commits last 24 bits");
    expect_val(0, 24'h1234, "R4 earlier word not committed");

    begin
      logic s0;
      s0 = sdo;
      for (int i = 0; i < 10; i++) begin
        sdin = 1'b1; sclk = 1'b0; repeat (4) @(negedge clk);
        sclk = 1'b1; repeat (4) @(negedge clk);
      end
      sdin = 1'b0;
      expect_val(6, {23'd0, s0}, "R6 idle clocks leave output");
      pulse_ldac();
      expect_val(3, 24'hCAFE, "R6 idle clocks load nothing");
    end

    frame(48'h820000, 24);
    frame(48'h180000, 24);
    expect_val(4, 24'h02BEEF, "R8 readback of channel 2");
    pulse_ldac();
    expect_val(2, 24'hBEEF, "R9 no-operation leaves registers");

    frame(48'h190001, 24);
    expect_val(5, 24'h0, "R9 output disabled");
    expect_val(6, 24'h0, "R9 output held low");
    frame(48'h990000, 24);
    frame(48'h180000, 24);
    expect_val(4, 24'h190001, "R8 readback of control");
    expect_val(7, 24'h1, "R9 enabled for readback frame");
    expect_val(5, 24'h0, "R9 disabled again after readback");
    frame(48'h190000, 24);
    expect_val(5, 24'h1, "R9 output re-enabled");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule